// File: doc/BRIEF.md
# Protected Region Descriptor Register File

This block stores the configuration of a memory protection unit: a set of region descriptors plus one global control word and one read-only hardware information word, all reached through a single-cycle register interface. Each descriptor has four 32-bit words. They give the region's first address, its last address, a per-master rights word, and a control word that carries the region valid bit. A build holds 8, 12 or 16 descriptors. The checker that enforces the rights on bus traffic sits outside this block. It reads the descriptors through the same interface and takes the valid flags directly from the outputs.

Every write carries the number of the bus master that issues it. Master 0 is the core and master 1 is the debugger. The debugger ranks highest, the core second and the other masters after them. Descriptor 0 comes out of reset covering the whole 32-bit space with full rights. Writes to it from any master other than the debugger are filtered field by field, so those masters cannot narrow the debugger's range or change the debugger's rights. Reads are combinational. A write takes effect at the clock edge where `wr_en_i` is high.

Top module: `rdf_top`

## Requirements
- R1: After reset, descriptor 0 reads start 0x00000000, end 0xFFFFFFFF, rights 0xFFFFFFFF and control 0x00000001. Every other implemented descriptor reads start 0, end 0x0000001F, rights 0 and control 0. The global control word reads 0.
- R2: Word address 1 is read-only and reads {22'b0, region code[9:8], slave port count[7:4], revision[3:0]}. The region code is 0 for 8 descriptors, 1 for 12 and 2 for 16. Writes to word address 1 change nothing.
- R3: Bits 4:0 of a start word always read 0, and bits 4:0 of an end word always read 1. Bits 31:5 read back what was last written.
- R4: In descriptor 0, a write to the start or end word from any master other than 1 is ignored. A write from master 1 takes effect.
- R5: In descriptor 0, a rights write from any master other than 1 updates every 4-bit master field except bits 7:4, which belong to master 1 and keep their value. Master m owns bits 4m+3:4m. A rights write from master 1 updates all bits.
- R6: Bit 0 of a descriptor's control word is its valid bit, and the other bits read 0. `region_valid_o[d]` equals the valid bit of descriptor d.
- R7: Bit 0 of the global control word (word address 0) is the global valid bit, driven on `glb_valid_o`. The other bits read 0.
- R8: A write to a descriptor index at or above the implemented count changes nothing. A read of such an index returns 0, and so does a read of any unmapped word address (2 to 63).
- R9: Address map: an address with bit 6 = 0 selects the base words. An address with bit 6 = 1 selects descriptor bits 5:2, word bits 1:0 (0 start, 1 end, 2 rights, 3 control). In descriptors other than 0, any master may write every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 7 | Write word address |
| wr_data_i | input | 32 | Write data |
| wr_master_i | input | 3 | Number of the master issuing the write |
| rd_addr_i | input | 7 | Read word address |
| rd_data_o | output | 32 | Read data (combinational) |
| glb_valid_o | output | 1 | Global valid bit |
| region_valid_o | output | NUM_DESC | Per-descriptor valid bits |

## Verification
A wrong stored bit becomes visible on `rd_data_o` as soon as the bench reads that word. The bench sweeps the whole address map after each directed phase and reads random addresses on every cycle, so a corrupted field shows up within one sweep. Errors in the descriptor 0 filter, such as a core write that moves the debugger's range or changes its rights field, appear on the first read after the edge that committed them. A wrong valid bit appears on `region_valid_o` or `glb_valid_o` in the same cycle as the faulty write edge, and the bench compares both against its model on every clock.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned GRAN_LSB = 5;
  localparam int unsigned RIGHTS_W = 4;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned ADDR_W   = 1 + IDX_W + 2;

  typedef enum logic [1:0] {
    W_START  = 2'd0,
    W_END    = 2'd1,
    W_RIGHTS = 2'd2,
    W_CTRL   = 2'd3
  } desc_word_e;

  function automatic logic [1:0] region_code(int unsigned n);
    return (n <= 8) ? 2'd0 : (n <= 12) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/rdf_glob.sv
module rdf_glob (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wbit_i,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_o <= 1'b0;
    else if (we_i) valid_o <= wbit_i;
  end

  assert_glob_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_o == $past(wbit_i)));
endmodule

// File: rtl/rdf_desc.sv
module rdf_desc
  import rdf_pkg::*;
#(
  parameter bit          IS_ROOT     = 1'b0,
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned DBG_MASTER  = 1,
  localparam int unsigned RT_W       = NUM_MASTERS * RIGHTS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  desc_word_e        word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] start_o,
  output logic [DATA_W-1:0] end_o,
  output logic [RT_W-1:0]   rights_o,
  output logic              valid_o
);
  localparam logic [RT_W-1:0] DBG_MASK = RT_W'({RIGHTS_W{1'b1}}) << (DBG_MASTER * RIGHTS_W);

  logic [DATA_W-1:GRAN_LSB] start_q, end_q;
  logic [RT_W-1:0]          rights_q;
  logic                     valid_q;
  logic                     lock;

  assign lock = IS_ROOT && !priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      end_q    <= IS_ROOT ? '1 : '0;
      rights_q <= IS_ROOT ? '1 : '0;
      valid_q  <= IS_ROOT;
    end else if (we_i) begin
      unique case (word_i)
        W_START:  if (!lock) start_q <= wdata_i[DATA_W-1:GRAN_LSB];
        W_END:    if (!lock) end_q   <= wdata_i[DATA_W-1:GRAN_LSB];
        W_RIGHTS: rights_q <= lock ? ((wdata_i[RT_W-1:0] & ~DBG_MASK) | (rights_q & DBG_MASK))
                                   : wdata_i[RT_W-1:0];
        W_CTRL:   valid_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign start_o  = {start_q, {GRAN_LSB{1'b0}}};
  assign end_o    = {end_q, {GRAN_LSB{1'b1}}};
  assign rights_o = rights_q;
  assign valid_o  = valid_q;

  if (IS_ROOT) begin : g_root_chk
    assert_root_range_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !priv_i && (word_i == W_START || word_i == W_END)) |=> ($stable(start_o) && $stable(end_o)));
    assert_root_dbg_rights_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !priv_i && word_i == W_RIGHTS) |=> ((rights_o & DBG_MASK) == ($past(rights_o) & DBG_MASK)));
  end
endmodule

// File: rtl/rdf_top.sv
module rdf_top
  import rdf_pkg::*;
#(
  parameter int unsigned NUM_DESC    = 12,
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned DBG_MASTER  = 1,
  parameter logic [3:0]  REVISION    = 4'h3,
  parameter logic [3:0]  NUM_SLAVES  = 4'h5,
  localparam int unsigned MST_W      = $clog2(NUM_MASTERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [MST_W-1:0]  wr_master_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              glb_valid_o,
  output logic [NUM_DESC-1:0] region_valid_o
);
  localparam int unsigned RT_W = NUM_MASTERS * RIGHTS_W;
  localparam logic [DATA_W-1:0] INFO_WORD =
    DATA_W'({region_code(NUM_DESC), NUM_SLAVES, REVISION});

  logic              wr_is_desc, rd_is_desc, priv;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  desc_word_e        wr_word;
  logic [DATA_W-1:0] dword [NUM_DESC][4];

  assign wr_is_desc = wr_addr_i[ADDR_W-1];
  assign wr_idx     = wr_addr_i[ADDR_W-2:2];
  assign wr_word    = desc_word_e'(wr_addr_i[1:0]);
  assign priv       = (wr_master_i == MST_W'(DBG_MASTER));
  assign rd_is_desc = rd_addr_i[ADDR_W-1];
  assign rd_idx     = rd_addr_i[ADDR_W-2:2];

  rdf_glob u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && !wr_is_desc && (wr_addr_i[ADDR_W-2:0] == '0)),
    .wbit_i  (wr_data_i[0]),
    .valid_o (glb_valid_o)
  );

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    logic [RT_W-1:0] rights;
    logic            valid;

    rdf_desc #(
      .IS_ROOT     (d == 0),
      .NUM_MASTERS (NUM_MASTERS),
      .DBG_MASTER  (DBG_MASTER)
    ) u_desc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && wr_is_desc && (wr_idx == IDX_W'(d))),
      .word_i   (wr_word),
      .wdata_i  (wr_data_i),
      .priv_i   (priv),
      .start_o  (dword[d][0]),
      .end_o    (dword[d][1]),
      .rights_o (rights),
      .valid_o  (valid)
    );

    assign dword[d][2]       = DATA_W'(rights);
    assign dword[d][3]       = DATA_W'(valid);
    assign region_valid_o[d] = valid;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_is_desc) begin
      if (32'(rd_idx) < NUM_DESC) rd_data_o = dword[rd_idx][rd_addr_i[1:0]];
    end else if (rd_addr_i[ADDR_W-2:0] == 'd0) begin
      rd_data_o = DATA_W'(glb_valid_o);
    end else if (rd_addr_i[ADDR_W-2:0] == 'd1) begin
      rd_data_o = INFO_WORD;
    end
  end

  assert_oob_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_is_desc && 32'(wr_idx) >= NUM_DESC) |=> $stable(region_valid_o));
  assert_info_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_W'(1)) |-> (rd_data_o[9:8] == region_code(NUM_DESC)));
endmodule

// File: tb/rdf_top_tb_top.sv
module rdf_top_tb_top;
  localparam int CLK_P = 10;
  localparam int ND    = 12;
  localparam logic [31:0] INFO_EXP = 32'h0000_0153;  // code 1, 5 slave ports, revision 3
  localparam logic [31:0] DBG_FLD  = 32'h0000_00F0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_mst = '0;
  logic [31:0] rd_data;
  logic        glb_valid;
  logic [ND-1:0] rvalid;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  logic [31:0] m_start[16], m_end[16], m_rights[16];
  logic        m_valid[16];
  logic        m_glob;

  always #(CLK_P/2) clk = ~clk;

  rdf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_master_i(wr_mst), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .glb_valid_o(glb_valid), .region_valid_o(rvalid)
  );

  function automatic logic [31:0] mread(int a);
    int d, w;
    if (a >= 64) begin
      d = (a >> 2) & 15; w = a & 3;
      if (d >= ND) return 32'h0;
      case (w)
        0: return {m_start[d][31:5], 5'h00};
        1: return {m_end[d][31:5], 5'h1f};
        2: return m_rights[d];
        default: return {31'h0, m_valid[d]};
      endcase
    end
    if (a == 0) return {31'h0, m_glob};
    if (a == 1) return INFO_EXP;
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    if (a < 64) return (a == 0) ? "R7" : (a == 1) ? "R2" : "R8";
    if (((a >> 2) & 15) >= ND) return "R8";
    case (a & 3)
      0, 1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic mwrite(int a, logic [31:0] v, int m);
    int d;
    bit lock;
    if (a >= 64) begin
      d = (a >> 2) & 15;
      if (d >= ND) return;
      lock = (d == 0) && (m != 1);
      case (a & 3)
        0: if (!lock) m_start[d] = v;
        1: if (!lock) m_end[d] = v;
        2: m_rights[d] = lock ? ((v & ~DBG_FLD) | (m_rights[d] & DBG_FLD)) : v;
        default: m_valid[d] = v[0];
      endcase
    end else if (a == 0) m_glob = v[0];
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (cmp_en) begin
    #(CLK_P/4);
    chk(tag_of(int'(rd_addr)), rd_data, mread(int'(rd_addr)));
    chk("R7", {31'h0, glb_valid}, {31'h0, m_glob});
    for (int d = 0; d < ND; d++) chk("R6", {31'h0, rvalid[d]}, {31'h0, m_valid[d]});
  end

  task automatic drive(bit we, int wa, logic [31:0] wd, int m, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = 7'(wa); wr_data = wd; wr_mst = 3'(m); rd_addr = 7'(ra);
    @(posedge clk);
    if (we) mwrite(wa, wd, m);
  endtask

  task automatic expect_rd(int a, logic [31:0] exp, string tag);
    drive(1'b0, 0, 0, 0, a);
    #(CLK_P/4);
    chk(tag, rd_data, exp);
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a++) drive(1'b0, 0, 0, 0, a);
  endtask

  function automatic int da(int d, int w);
    return 64 + d * 4 + w;
  endfunction

  initial begin
    for (int d = 0; d < 16; d++) begin
      m_start[d] = 0; m_end[d] = 0; m_rights[d] = 0; m_valid[d] = 0;
    end
    m_end[0] = 32'hFFFF_FFFF; m_rights[0] = 32'hFFFF_FFFF; m_valid[0] = 1'b1; m_glob = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1 reset state
    expect_rd(da(0, 1), 32'hFFFF_FFFF, "R1");
    expect_rd(da(0, 2), 32'hFFFF_FFFF, "R1");
    expect_rd(da(0, 3), 32'h1, "R1");
    expect_rd(da(4, 1), 32'h1F, "R1");
    expect_rd(0, 32'h0, "R1");
    sweep();
    // R2 info word ignores writes
    drive(1'b1, 1, 32'hFFFF_FFFF, 1, 1);
    expect_rd(1, INFO_EXP, "R2");
    // R4 core cannot move root range; R5 debugger field kept
    drive(1'b1, da(0, 0), 32'h1000_0000, 0, 0);
    drive(1'b1, da(0, 1), 32'h2000_0000, 0, 0);
    drive(1'b1, da(0, 2), 32'h0000_0000, 0, 0);
    expect_rd(da(0, 0), 32'h0, "R4");
    expect_rd(da(0, 1), 32'hFFFF_FFFF, "R4");
    expect_rd(da(0, 2), 32'h0000_00F0, "R5");
    drive(1'b1, da(0, 2), 32'h1234_5A06, 5, 0);
    expect_rd(da(0, 2), 32'h1234_5AF6, "R5");
    // R4 debugger may change the root
    drive(1'b1, da(0, 0), 32'h4000_0013, 1, 0);
    drive(1'b1, da(0, 2), 32'h0000_0000, 1, 0);
    expect_rd(da(0, 0), 32'h4000_0000, "R4");
    expect_rd(da(0, 2), 32'h0, "R5");
    // R9 normal descriptor, any master; R3 granule bits
    drive(1'b1, da(5, 0), 32'h8000_1FFF, 6, 0);
    drive(1'b1, da(5, 1), 32'h8000_2000, 6, 0);
    drive(1'b1, da(5, 3), 32'hFFFF_FFFF, 6, 0);
    expect_rd(da(5, 0), 32'h8000_1FE0, "R9");
    expect_rd(da(5, 1), 32'h8000_201F, "R3");
    expect_rd(da(5, 3), 32'h1, "R6");
    // R8 out-of-range descriptor
    drive(1'b1, da(13, 3), 32'h1, 0, 0);
    drive(1'b1, da(13, 2), 32'hFFFF_FFFF, 1, 0);
    expect_rd(da(13, 2), 32'h0, "R8");
    // R7 global valid
    drive(1'b1, 0, 32'hFFFF_FFFF, 2, 0);
    expect_rd(0, 32'h1, "R7");
    sweep();
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 64) : 64 + int'($urandom % 64);
      if ($urandom % 3 == 0) a = 64 + int'($urandom % 4);
      drive(($urandom % 2) == 1, a, $urandom, int'($urandom % 8), int'($urandom % 128));
    end
    sweep();
    drive(1'b0, 0, 0, 0, 0);
    cmp_en = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule